// File: doc/BRIEF.md
# Sine/Cosine Phase-to-Amplitude Converter

This block turns the upper bits of an oscillator's phase accumulator into a pair of 8-bit quadrature samples. A 12-bit phase word arrives every clock. Its ten upper bits address a 1024-step sine table, and the matching cosine comes from the same table a quarter turn ahead. Both samples are in offset-binary code, so 0x00 is the negative peak, 0xFF the positive peak, and the cycle average sits at 127.5. Each table point is taken half a step past its nominal phase. That keeps the table exactly antisymmetric and gives 0x81 for sine at zero phase.

Two select inputs let a system trade the samples for raw phase bits, for example to address a finer external table. With the sine select high, the sine bus carries phase bits 11..4 in reversed bit order. With the cosine select low, the two lowest cosine bits carry phase bits 1..0. Phase bits 3..2 always have their own output pins. Every output is registered, and the samples, the selected bits and the dedicated pins all appear together one clock after the phase word.

The table is computed in the code at elaboration. By default only one quadrant is stored, and the other three are obtained by mirroring the address and inverting the code.

Top module: `sincos_pac`

## Requirements
- R1: With `sel_sin_phase_i` low, `sin_o` equals the table entry addressed by `phase_i[11:2]`, one clock after `phase_i` is presented.
- R2: For an address n below 512, the entry is V(n) = min(255, 128 + ceil(127.5·sin(2π(n+0.5)/1024))). For n from 512 to 1023, the entry is 255 − V(n−512).
- R3: `cos_o` (cosine select high) equals the table entry at address (n + 256) mod 1024, where n = `phase_i[11:2]`.
- R4: At phase address 0, the sine sample is 0x81 and the cosine sample is 0xFF.
- R5: Over all 1024 addresses, the sine samples sum to 130560, which is an average of 127.5.
- R6: With `sel_sin_phase_i` high, `sin_o[i]` carries `phase_i[11−i]` for i = 0..7. So bit 0 carries phase bit 11 and bit 7 carries phase bit 4.
- R7: With `sel_cos_full_i` low, `cos_o[1:0]` carries `phase_i[1:0]` and `cos_o[7:2]` keeps the cosine sample's bits 7..2.
- R8: With `sel_cos_full_i` high, all eight bits of `cos_o` carry the cosine sample.
- R9: `ph_mid_o` carries `phase_i[3:2]` one clock later, whatever the selects are set to.
- R10: A clock edge with `rst` high sets `sin_o`, `cos_o` and `ph_mid_o` to zero. The first edge after `rst` falls shows the current inputs again.
- R11: A change on `phase_i` or on either select reaches the outputs at the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | 12 | Top bits of the phase accumulator |
| sel_sin_phase_i | input | 1 | 1: sine bus carries reversed phase bits 11..4 |
| sel_cos_full_i | input | 1 | 0: cosine bits 1..0 carry phase bits 1..0 |
| sin_o | output | 8 | Sine sample or reversed phase bits |
| cos_o | output | 8 | Cosine sample, optionally with phase bits in bits 1..0 |
| ph_mid_o | output | 2 | Phase bits 3..2, always driven |

## Verification
The hardest condition to reach from the ports is the quadrant folding. An error in the mirrored address or in the inverted code shows up only at addresses in the second, third and fourth quarter turns, and often only a few codes from the peaks. The stimulus therefore sweeps every one of the 1024 addresses with both selects in their sample positions. It compares each sine and cosine sample against an independently computed half-wave rule and totals the sine codes for the average check. Fixed vectors placed exactly at the quadrant boundaries, with chosen low phase bits, pin down the multiplexed bit positions against sample values that are known in advance.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  localparam int SC_PHASE_W = 12;
  localparam int SC_ADDR_W  = 10;
  localparam int SC_AMP_W   = 8;

  localparam real SC_PI = 3.14159265358979323846;

  // Code for an address in the first half cycle: centre plus rounded-up
  // excursion, sampled half a step past the nominal phase.
  function automatic int half_code(int n, int addr_w, int amp_w);
    real theta;
    real excur;
    int  code;
    int  top;
    top   = (1 << amp_w) - 1;
    theta = 2.0 * SC_PI * (real'(n) + 0.5) / real'(1 << addr_w);
    excur = (real'(top) / 2.0) * $sin(theta);
    code  = (1 << (amp_w - 1)) + int'($ceil(excur));
    if (code > top) code = top;
    if (code < 0)   code = 0;
    return code;
  endfunction

  // Code for any address: the second half is the offset-binary negation.
  function automatic int full_code(int n, int addr_w, int amp_w);
    int half;
    half = 1 << (addr_w - 1);
    if (n < half) return half_code(n, addr_w, amp_w);
    return ((1 << amp_w) - 1) - half_code(n - half, addr_w, amp_w);
  endfunction

endpackage

// File: rtl/sincos_rom.sv
module sincos_rom #(
  parameter int ADDR_W  = sincos_pkg::SC_ADDR_W,
  parameter int AMP_W   = sincos_pkg::SC_AMP_W,
  parameter bit QUARTER = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  output logic [AMP_W-1:0]  amp_a_o,
  output logic [AMP_W-1:0]  amp_b_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int QW    = ADDR_W - 2;
  localparam int QD    = 1 << QW;

  generate
    if (QUARTER) begin : g_quarter
      logic [AMP_W-1:0] qtab [QD];

      initial begin
        for (int k = 0; k < QD; k++) begin
          qtab[k] = AMP_W'(sincos_pkg::half_code(k, ADDR_W, AMP_W));
        end
      end

      function automatic logic [AMP_W-1:0] fold(logic [ADDR_W-1:0] a,
                                                logic [AMP_W-1:0] t [QD]);
        logic [1:0]       quad;
        logic [QW-1:0]    idx;
        logic [AMP_W-1:0] raw;
        quad = a[ADDR_W-1 -: 2];
        idx  = quad[0] ? ~a[QW-1:0] : a[QW-1:0];
        raw  = t[idx];
        return quad[1] ? ~raw : raw;
      endfunction

      assign amp_a_o = fold(addr_a_i, qtab);
      assign amp_b_o = fold(addr_b_i, qtab);
    end else begin : g_full
      logic [AMP_W-1:0] ftab [DEPTH];

      initial begin
        for (int n = 0; n < DEPTH; n++) begin
          ftab[n] = AMP_W'(sincos_pkg::full_code(n, ADDR_W, AMP_W));
        end
      end

      assign amp_a_o = ftab[addr_a_i];
      assign amp_b_o = ftab[addr_b_i];
    end
  endgenerate

endmodule

// File: rtl/sincos_outmux.sv
module sincos_outmux #(
  parameter int PHASE_W = sincos_pkg::SC_PHASE_W,
  parameter int ADDR_W  = sincos_pkg::SC_ADDR_W,
  parameter int AMP_W   = sincos_pkg::SC_AMP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               sel_a_i,
  input  logic               sel_b_i,
  input  logic [AMP_W-1:0]   amp_s_i,
  input  logic [AMP_W-1:0]   amp_c_i,
  output logic [AMP_W-1:0]   sin_o,
  output logic [AMP_W-1:0]   cos_o,
  output logic [ADDR_W-AMP_W-1:0] mid_o
);

  localparam int LOW_W = PHASE_W - ADDR_W;
  localparam int MID_W = ADDR_W - AMP_W;
  localparam int MID_T = PHASE_W - AMP_W - 1;

  logic [AMP_W-1:0] phase_rev;
  logic [AMP_W-1:0] cos_mix;

  generate
    for (genvar i = 0; i < AMP_W; i++) begin : g_rev
      assign phase_rev[i] = phase_i[PHASE_W-1-i];
    end
  endgenerate

  assign cos_mix = {amp_c_i[AMP_W-1:LOW_W], phase_i[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o <= '0;
      cos_o <= '0;
      mid_o <= '0;
    end else begin
      sin_o <= sel_a_i ? phase_rev : amp_s_i;
      cos_o <= sel_b_i ? amp_c_i : cos_mix;
      mid_o <= phase_i[MID_T -: MID_W];
    end
  end

endmodule

// File: rtl/sincos_pac.sv
module sincos_pac #(
  parameter int PHASE_W = sincos_pkg::SC_PHASE_W,
  parameter int ADDR_W  = sincos_pkg::SC_ADDR_W,
  parameter int AMP_W   = sincos_pkg::SC_AMP_W,
  parameter bit QUARTER = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               sel_sin_phase_i,
  input  logic               sel_cos_full_i,
  output logic [AMP_W-1:0]   sin_o,
  output logic [AMP_W-1:0]   cos_o,
  output logic [ADDR_W-AMP_W-1:0] ph_mid_o
);

  localparam int                QTR_OFS  = 1 << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] QTR_STEP = ADDR_W'(QTR_OFS);

  // Named internal events for the checker.
  logic [ADDR_W-1:0] sin_addr;
  logic [ADDR_W-1:0] cos_addr;
  logic [AMP_W-1:0]  sin_amp;
  logic [AMP_W-1:0]  cos_amp;

  assign sin_addr = phase_i[PHASE_W-1 -: ADDR_W];
  assign cos_addr = sin_addr + QTR_STEP;

  sincos_rom #(
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W),
    .QUARTER(QUARTER)
  ) rom_i (
    .addr_a_i(sin_addr),
    .addr_b_i(cos_addr),
    .amp_a_o (sin_amp),
    .amp_b_o (cos_amp)
  );

  sincos_outmux #(
    .PHASE_W(PHASE_W),
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W)
  ) mux_i (
    .clk    (clk),
    .rst    (rst),
    .phase_i(phase_i),
    .sel_a_i(sel_sin_phase_i),
    .sel_b_i(sel_cos_full_i),
    .amp_s_i(sin_amp),
    .amp_c_i(cos_amp),
    .sin_o  (sin_o),
    .cos_o  (cos_o),
    .mid_o  (ph_mid_o)
  );

endmodule

// File: rtl/sincos_pac_chk.sv
module sincos_pac_chk #(
  parameter int PHASE_W = sincos_pkg::SC_PHASE_W,
  parameter int ADDR_W  = sincos_pkg::SC_ADDR_W,
  parameter int AMP_W   = sincos_pkg::SC_AMP_W
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] phase_i,
  input logic               sel_sin_phase_i,
  input logic               sel_cos_full_i,
  input logic [AMP_W-1:0]   sin_o,
  input logic [AMP_W-1:0]   cos_o,
  input logic [ADDR_W-AMP_W-1:0] ph_mid_o,
  input logic [AMP_W-1:0]   sin_amp,
  input logic [AMP_W-1:0]   cos_amp
);

  localparam int               LOW_W  = PHASE_W - ADDR_W;
  localparam logic [AMP_W-1:0] Z_SIN  = AMP_W'((1 << (AMP_W - 1)) + 1);
  localparam logic [AMP_W-1:0] Z_COS  = {AMP_W{1'b1}};

  function automatic logic [AMP_W-1:0] top_reversed(logic [PHASE_W-1:0] p);
    logic [AMP_W-1:0] r;
    for (int i = 0; i < AMP_W; i++) r[AMP_W-1-i] = p[PHASE_W-AMP_W+i];
    return r;
  endfunction

  assert_sine_sample_R1: assert property (@(posedge clk) disable iff (rst)
    !sel_sin_phase_i |=> sin_o == $past(sin_amp));

  assert_zero_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_i[PHASE_W-1 -: ADDR_W] == '0) |-> (sin_amp == Z_SIN && cos_amp == Z_COS));

  assert_sine_bus_reversed_R6: assert property (@(posedge clk) disable iff (rst)
    sel_sin_phase_i |=> sin_o == top_reversed($past(phase_i)));

  assert_cos_low_bits_R7: assert property (@(posedge clk) disable iff (rst)
    !sel_cos_full_i |=> (cos_o[LOW_W-1:0] == $past(phase_i[LOW_W-1:0]) &&
                         cos_o[AMP_W-1:LOW_W] == $past(cos_amp[AMP_W-1:LOW_W])));

  assert_cos_full_R8: assert property (@(posedge clk) disable iff (rst)
    sel_cos_full_i |=> cos_o == $past(cos_amp));

  assert_mid_bits_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ph_mid_o == $past(phase_i[PHASE_W-AMP_W-1 -: ADDR_W-AMP_W]));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (sin_o == '0 && cos_o == '0 && ph_mid_o == '0));

endmodule

bind sincos_pac sincos_pac_chk #(
  .PHASE_W(PHASE_W),
  .ADDR_W (ADDR_W),
  .AMP_W  (AMP_W)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .phase_i        (phase_i),
  .sel_sin_phase_i(sel_sin_phase_i),
  .sel_cos_full_i (sel_cos_full_i),
  .sin_o          (sin_o),
  .cos_o          (cos_o),
  .ph_mid_o       (ph_mid_o),
  .sin_amp        (sin_amp),
  .cos_amp        (cos_amp)
);

// File: tb/sincos_pac_tb_top.sv
module sincos_pac_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] phase = '0;
  logic        sa = 1'b0;
  logic        sb = 1'b1;
  logic [7:0]  sin_o;
  logic [7:0]  cos_o;
  logic [1:0]  mid_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  sincos_pac dut_i (
    .clk            (clk),
    .rst            (rst),
    .phase_i        (phase),
    .sel_sin_phase_i(sa),
    .sel_cos_full_i (sb),
    .sin_o          (sin_o),
    .cos_o          (cos_o),
    .ph_mid_o       (mid_o)
  );

  typedef struct packed {
    logic [11:0] ph;
    logic        sa;
    logic        sb;
    logic [7:0]  e_sin;
    logic [7:0]  e_cos;
    logic [7:0]  cmask;
    logic [1:0]  e_mid;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 1'b0, 1'b1, 8'h81, 8'hFF, 8'hFF, 2'd0},
    '{12'h400, 1'b0, 1'b1, 8'hFF, 8'h7E, 8'hFF, 2'd0},
    '{12'h800, 1'b0, 1'b1, 8'h7E, 8'h00, 8'hFF, 2'd0},
    '{12'hC00, 1'b0, 1'b1, 8'h00, 8'h81, 8'hFF, 2'd0},
    '{12'h001, 1'b1, 1'b0, 8'h00, 8'hFD, 8'hFF, 2'd0},
    '{12'h402, 1'b1, 1'b0, 8'h02, 8'h7E, 8'hFF, 2'd0},
    '{12'h803, 1'b1, 1'b0, 8'h01, 8'h03, 8'hFF, 2'd0},
    '{12'hC01, 1'b1, 1'b0, 8'h03, 8'h81, 8'hFF, 2'd0},
    '{12'h3AE, 1'b1, 1'b0, 8'h5C, 8'h02, 8'h03, 2'd3},
    '{12'hE17, 1'b1, 1'b0, 8'h87, 8'h03, 8'h03, 2'd1},
    '{12'h5F8, 1'b1, 1'b0, 8'hFA, 8'h00, 8'h03, 2'd2},
    '{12'h001, 1'b0, 1'b0, 8'h81, 8'hFD, 8'hFF, 2'd0}
  };

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Independent restatement of the table rule: direct half-wave formula.
  function automatic int model(int a);
    real v;
    int  c;
    int  m;
    m = a % 1024;
    if (m >= 512) return 255 - model(m - 512);
    v = 127.5 * $sin(2.0 * 3.14159265358979323846 * (real'(m) + 0.5) / 1024.0);
    c = 128 + int'($ceil(v));
    return (c > 255) ? 255 : c;
  endfunction

  task automatic drive(logic [11:0] p, logic a, logic b);
    @(negedge clk);
    phase = p;
    sa    = a;
    sb    = b;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int sum;
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10 sin in reset", sin_o, 0);
    check("R10 cos in reset", cos_o, 0);
    check("R10 mid in reset", mid_o, 0);
    phase = 12'h000; sa = 1'b0; sb = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check("R10 R4 sin after release", sin_o, 8'h81);
    check("R4 cos at zero phase", cos_o, 8'hFF);

    // Vector walk: R1 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ph, VECS[i].sa, VECS[i].sb);
      @(negedge clk);
      check(VECS[i].sa ? "R6 sine bus phase bits" : "R1 sine sample",
            sin_o, VECS[i].e_sin);
      check(VECS[i].sb ? "R8 cosine full" : "R7 cosine low bits",
            cos_o & VECS[i].cmask, VECS[i].e_cos & VECS[i].cmask);
      check("R9 dedicated phase bits", mid_o, VECS[i].e_mid);
    end

    // R11: change lands only at the next edge
    drive(12'h000, 1'b0, 1'b1);
    @(negedge clk);
    phase = 12'h5F8; sa = 1'b1;
    #2;
    check("R11 sine before edge", sin_o, 8'h81);
    @(negedge clk);
    check("R11 sine after edge", sin_o, 8'hFA);

    // Full sweep: R2 R3 R5
    sum = 0;
    for (int a = 0; a < 1024; a++) begin
      drive({a[9:0], a[1:0]}, 1'b0, 1'b1);
      @(negedge clk);
      check("R2 sine entry", sin_o, model(a));
      check("R3 cosine entry", cos_o, model(a + 256));
      sum += int'(sin_o);
    end
    check("R5 sine sum over cycle", sum, 130560);

    // R10: reset in mid-run, then recovery
    drive(12'h3AE, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 sin mid-run reset", sin_o, 0);
    check("R10 cos mid-run reset", cos_o, 0);
    check("R10 mid mid-run reset", mid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 R6 sine after recovery", sin_o, 8'h5C);
    check("R10 R9 mid after recovery", mid_o, 3);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule